// File: doc/BRIEF.md
# Compressed Branch Address Packet Encoder

This block turns branch target addresses from a processor trace port into a stream of 8-bit trace packets. It keeps the last address it sent. For each new branch it sends only the low-order 7-bit groups needed to cover every bit that changed. This is one to five packets per branch. A decoder that rebuilds the address overwrites the matching low bits of its own copy with the bits it receives. No addition or subtraction is involved.

Each packet carries seven address bits plus a continuation flag in its top bit. The first packet of each branch is marked with a sync strobe. The fifth packet also carries the target instruction state: normal, or the alternate bytecode state. A branch that changes that state is always sent in full, so the state bit always reaches the decoder. Requests are accepted with a simple valid/busy handshake, and packets leave one per clock.

Top module: `trace_branch_encoder`

## Requirements
- R1: Bit 7 of every packet except the last of a branch is 1. The last packet has bit 7 = 0, except when it is the fifth packet. In that case bit 7 holds the target state.
- R2: Packet k (k = 1..4) carries address bits [7k-1:7k-7] in bits [6:0]. Packet 5 carries A[31:28] in bits [3:0] with bits [6:4] = 0.
- R3: `pkt_sync_o` is 1 on the first packet of each branch and 0 on every later packet.
- R4: The packet count is the smallest n whose groups cover the highest bit that differs from the stored address. Highest changed bit in 0..6 gives 1, 7..13 gives 2, 14..20 gives 3, 21..27 gives 4, and 28..31 gives 5.
- R5: A branch whose address equals the stored address produces exactly one packet holding A[6:0] with bit 7 = 0.
- R6: After reset the outputs are idle, the stored address is zero, the stored state is normal, and the first accepted branch is sent as five packets.
- R7: A branch whose state input (`br_alt_i`, 1 = alternate) differs from the stored state is sent as five packets. Bit 7 of the fifth packet equals `br_alt_i`.
- R8: A request is accepted on a clock edge where `br_valid_i` = 1 and `br_busy_o` = 0. Its first packet appears in the next cycle, and the packets follow on consecutive cycles with `br_busy_o` = 1. Requests made while busy are ignored.
- R9: The stored address and state are replaced by those of each accepted request. Later comparisons use them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid_i | input | 1 | Branch request |
| br_addr_i | input | 32 | Branch target address |
| br_alt_i | input | 1 | Target state: 1 = alternate bytecode state, 0 = normal |
| br_busy_o | output | 1 | Encoder is sending; requests ignored |
| pkt_valid_o | output | 1 | A packet is presented this cycle |
| pkt_data_o | output | 8 | Packet: bit 7 continuation/state, bits 6:0 payload |
| pkt_sync_o | output | 1 | First packet of a branch |

## Verification
On every cycle, the embedded properties check that each accepted request starts a synced packet one cycle later, and that sync never repeats within one branch. They also check that non-final packets carry the continuation bit, that the fifth packet pads its unused bits, and that a state change forces a full length. Only the bench's reference model and scenarios can show the exact packet counts for each highest-changed bit position. The same holds for the byte-exact payloads, the single-packet case when the address repeats, the value of the state bit in the fifth packet, and that a request raised mid-branch leaves no trace.

// File: rtl/tbe_pkg.sv
package tbe_pkg;
   typedef enum logic {
      ISA_NORMAL = 1'b0,
      ISA_ALT    = 1'b1
   } isa_e;
endpackage

// File: rtl/tbe_span.sv
// Counts how many low-order groups must be sent to cover every changed bit.
module tbe_span #(
   parameter int ADDR_W = 32,
   parameter int GRP_W  = 7,
   parameter int NPKT   = 5,
   parameter int CNT_W  = 3
) (
   input  logic [ADDR_W-1:0] new_addr,
   input  logic [ADDR_W-1:0] ref_addr,
   input  logic              force_full,
   output logic [CNT_W-1:0]  n_pkts
);
   logic [ADDR_W-1:0] diff;
   logic [NPKT-1:0]   grp_chg;

   assign diff = new_addr ^ ref_addr;

   for (genvar g = 0; g < NPKT; g++) begin : g_grp
      localparam int LO = g * GRP_W;
      localparam int HI = (LO + GRP_W - 1 > ADDR_W - 1) ? ADDR_W - 1 : LO + GRP_W - 1;
      assign grp_chg[g] = |diff[HI:LO];
   end

   always_comb begin
      n_pkts = CNT_W'(1);
      for (int g = 1; g < NPKT; g++) begin
         if (grp_chg[g]) n_pkts = CNT_W'(g + 1);
      end
      if (force_full) n_pkts = CNT_W'(NPKT);
   end
endmodule

// File: rtl/tbe_serializer.sv
// Shifts the captured address out one group per clock.
module tbe_serializer #(
   parameter int ADDR_W = 32,
   parameter int GRP_W  = 7,
   parameter int PKT_W  = 8,
   parameter int NPKT   = 5,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [CNT_W-1:0]  load_n,
   input  logic              load_alt,
   output logic              active,
   output logic              sync,
   output logic              last,
   output logic [PKT_W-1:0]  data
);
   localparam int LAST_W = ADDR_W - (NPKT - 1) * GRP_W;

   logic [ADDR_W-1:0] shreg_q;
   logic [CNT_W-1:0]  remain_q;
   logic [CNT_W-1:0]  idx_q;
   logic              alt_q;
   logic              cont;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q  <= '0;
         remain_q <= '0;
         idx_q    <= '0;
         alt_q    <= 1'b0;
         active   <= 1'b0;
         sync     <= 1'b0;
      end else if (load) begin
         shreg_q  <= load_addr;
         remain_q <= load_n;
         idx_q    <= '0;
         alt_q    <= load_alt;
         active   <= 1'b1;
         sync     <= 1'b1;
      end else if (active) begin
         shreg_q  <= shreg_q >> GRP_W;
         remain_q <= remain_q - CNT_W'(1);
         idx_q    <= idx_q + CNT_W'(1);
         sync     <= 1'b0;
         if (remain_q == CNT_W'(1)) active <= 1'b0;
      end
   end

   assign last = active && (remain_q == CNT_W'(1));

   always_comb begin
      if (!last)                         cont = 1'b1;
      else if (idx_q == CNT_W'(NPKT - 1)) cont = alt_q;
      else                               cont = 1'b0;
   end

   assign data = active ? {cont, shreg_q[GRP_W-1:0]} : '0;

   // R1: non-final packets announce a follower
   a_r1_cont_set: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !last) |-> data[PKT_W-1]);

   // R3: no second sync inside one branch
   a_r3_sync_once: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !last) |=> (active && !sync));

   if (LAST_W < GRP_W) begin : g_pad_chk
      // R2: unused high payload bits of the top group are zero
      a_r2_top_pad: assert property (@(posedge clk) disable iff (!rst_n)
         (active && idx_q == CNT_W'(NPKT - 1)) |-> (data[GRP_W-1:LAST_W] == '0));
   end
endmodule

// File: rtl/trace_branch_encoder.sv
module trace_branch_encoder #(
   parameter int ADDR_W = 32,
   parameter int GRP_W  = 7,
   parameter int PKT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              br_valid_i,
   input  logic [ADDR_W-1:0] br_addr_i,
   input  logic              br_alt_i,
   output logic              br_busy_o,
   output logic              pkt_valid_o,
   output logic [PKT_W-1:0]  pkt_data_o,
   output logic              pkt_sync_o
);
   import tbe_pkg::*;

   localparam int NPKT  = (ADDR_W + GRP_W - 1) / GRP_W;
   localparam int CNT_W = $clog2(NPKT + 1);

   if (PKT_W != GRP_W + 1) begin : g_bad_pkt
      $error("PKT_W must be GRP_W plus one continuation bit");
   end
   if (ADDR_W <= GRP_W) begin : g_bad_addr
      $error("ADDR_W must exceed one group");
   end
   if (ADDR_W - (NPKT - 1) * GRP_W >= GRP_W + 1) begin : g_bad_top
      $error("top group overflows its packet");
   end

   logic [ADDR_W-1:0] last_addr_q;
   isa_e              last_state_q;
   logic              full_q;
   logic              active;
   logic              last;
   logic              accept;
   logic              force_full;
   logic [CNT_W-1:0]  n_pkts;

   assign accept     = br_valid_i && !active;
   assign force_full = full_q || (isa_e'(br_alt_i) != last_state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_addr_q  <= '0;
         last_state_q <= ISA_NORMAL;
         full_q       <= 1'b1;
      end else if (accept) begin
         last_addr_q  <= br_addr_i;
         last_state_q <= isa_e'(br_alt_i);
         full_q       <= 1'b0;
      end
   end

   tbe_span #(
      .ADDR_W(ADDR_W), .GRP_W(GRP_W), .NPKT(NPKT), .CNT_W(CNT_W)
   ) i_span (
      .new_addr  (br_addr_i),
      .ref_addr  (last_addr_q),
      .force_full(force_full),
      .n_pkts    (n_pkts)
   );

   tbe_serializer #(
      .ADDR_W(ADDR_W), .GRP_W(GRP_W), .PKT_W(PKT_W), .NPKT(NPKT), .CNT_W(CNT_W)
   ) i_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_addr(br_addr_i),
      .load_n   (n_pkts),
      .load_alt (br_alt_i),
      .active   (active),
      .sync     (pkt_sync_o),
      .last     (last),
      .data     (pkt_data_o)
   );

   assign br_busy_o   = active;
   assign pkt_valid_o = active;

   // R8: an accepted request opens a synced packet on the next cycle
   a_r8_accept_start: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (pkt_valid_o && pkt_sync_o));

   // R8: the handshake stays busy until the final packet
   a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid_o && !last) |=> br_busy_o);

   // R4: packet count lies within one..NPKT
   a_r4_len_range: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (n_pkts >= CNT_W'(1) && n_pkts <= CNT_W'(NPKT)));

   // R7: a state change gives a full-length address
   a_r7_full_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (isa_e'(br_alt_i) != last_state_q)) |-> (n_pkts == CNT_W'(NPKT)));

   // R6: sync is never shown without a packet
   a_r6_sync_valid: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_sync_o |-> pkt_valid_o);
endmodule

// File: tb/test_trace_branch_encoder.sv
module test_trace_branch_encoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        br_valid_i = 1'b0;
   logic [31:0] br_addr_i = '0;
   logic        br_alt_i = 1'b0;
   logic        br_busy_o;
   logic        pkt_valid_o;
   logic [7:0]  pkt_data_o;
   logic        pkt_sync_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   trace_branch_encoder i_trace_branch_encoder (
      .clk(clk), .rst_n(rst_n), .br_valid_i(br_valid_i), .br_addr_i(br_addr_i),
      .br_alt_i(br_alt_i), .br_busy_o(br_busy_o), .pkt_valid_o(pkt_valid_o),
      .pkt_data_o(pkt_data_o), .pkt_sync_o(pkt_sync_o));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Behavioural reference: queue of {sync, byte} expected per output cycle
   logic [8:0]  expq[$];
   logic [31:0] m_last;
   bit          m_alt;
   bit          m_first;

   always @(posedge clk) begin
      if (!rst_n) begin
         expq.delete();
         m_last  = '0;
         m_alt   = 0;
         m_first = 1;
      end else if (expq.size() > 0) begin
         void'(expq.pop_front());
      end else if (br_valid_i) begin
         logic [31:0] d;
         int h;
         int n;
         d = br_addr_i ^ m_last;
         h = -1;
         for (int b = 0; b < 32; b++) if (d[b]) h = b;
         n = (h < 0) ? 1 : h / 7 + 1;
         if (m_first || (br_alt_i != m_alt)) n = 5;
         for (int k = 0; k < n; k++) begin
            logic [7:0] p;
            logic [31:0] s;
            s = br_addr_i >> (7 * k);
            p[6:0] = s[6:0];
            p[7] = (k < n - 1) ? 1'b1 : ((k == 4) ? br_alt_i : 1'b0);
            expq.push_back({(k == 0), p});
         end
         m_last  = br_addr_i;
         m_alt   = br_alt_i;
         m_first = 0;
      end
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         chk(!pkt_valid_o && !br_busy_o && !pkt_sync_o, "R6", "idle in reset",
             {29'd0, pkt_valid_o, br_busy_o, pkt_sync_o}, 32'd0);
      end else if (!done) begin
         if (expq.size() > 0) begin
            chk(pkt_valid_o && br_busy_o, "R8", "valid/busy while sending",
                {30'd0, pkt_valid_o, br_busy_o}, 32'd3);
            chk(pkt_sync_o == expq[0][8], "R3", "sync", {31'd0, pkt_sync_o}, {31'd0, expq[0][8]});
            chk(pkt_data_o[7] == expq[0][7], "R1", "continuation bit",
                {31'd0, pkt_data_o[7]}, {31'd0, expq[0][7]});
            chk(pkt_data_o[6:0] == expq[0][6:0], "R2", "payload",
                {25'd0, pkt_data_o[6:0]}, {25'd0, expq[0][6:0]});
         end else begin
            chk(!pkt_valid_o && !br_busy_o, "R8", "idle between branches",
                {30'd0, pkt_valid_o, br_busy_o}, 32'd0);
         end
      end
   end

   // Issue one branch and count its packets; optional poke raises a request mid-branch
   task automatic send(input logic [31:0] a, input bit alt, input int exp_n,
                       input string req, input bit poke);
      int cnt;
      logic [7:0] lastb;
      while (br_busy_o) @(negedge clk);
      br_valid_i = 1'b1;
      br_addr_i  = a;
      br_alt_i   = alt;
      @(negedge clk);
      br_valid_i = 1'b0;
      cnt = 0;
      lastb = '0;
      while (pkt_valid_o) begin
         cnt++;
         lastb = pkt_data_o;
         if (poke && cnt == 2) begin
            br_valid_i = 1'b1;
            br_addr_i  = ~a;
            br_alt_i   = !alt;
         end
         if (poke && cnt == 3) br_valid_i = 1'b0;
         @(negedge clk);
      end
      chk(cnt == exp_n, req, "packet count", cnt, exp_n);
      if (exp_n == 5) chk(lastb[7] == alt, "R7", "fifth packet state bit", {31'd0, lastb[7]}, {31'd0, alt});
      else            chk(lastb[7] == 1'b0, "R1", "final bit7 low", {31'd0, lastb[7]}, 32'd0);
   endtask

   initial begin
      logic [31:0] base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      base = 32'h1234_5678;
      send(base, 0, 5, "R6", 0);                  // first branch after reset
      base ^= 32'h1;           send(base, 0, 1, "R4", 0);
      send(base, 0, 1, "R5", 0);                  // identical address
      base ^= (32'h1 << 19);   send(base, 0, 3, "R4", 0);
      base ^= (32'h1 << 13);   send(base, 0, 2, "R4", 0);
      base ^= (32'h1 << 14);   send(base, 0, 3, "R4", 0);
      base ^= (32'h1 << 27);   send(base, 0, 4, "R4", 0);
      base ^= (32'h1 << 28);   send(base, 0, 5, "R4", 0);
      base ^= (32'h1 << 7);    send(base, 0, 2, "R9", 0);
      base ^= (32'h1 << 6);    send(base, 0, 1, "R4", 0);
      base ^= 32'h1;           send(base, 1, 5, "R7", 0);  // into alternate state
      base ^= (32'h1 << 3);    send(base, 1, 1, "R7", 0);
      base ^= (32'h1 << 30);   send(base, 1, 5, "R4", 0);  // full length, state bit high
      send(base, 0, 5, "R7", 0);                           // back to normal
      base ^= (32'h1 << 29);   send(base, 0, 5, "R8", 1);  // request while busy ignored
      base ^= (32'h1 << 2);    send(base, 0, 1, "R8", 0);  // compared with the kept base
      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule